// File: doc/BRIEF.md
# Multichannel Parallel ADC Sequencer

This block runs an external 12-bit, eight-input successive-approximation converter over an 8-bit parallel bus. It samples several biopotential leads in turn. A divider built into the block makes a sample-rate tick from the system clock. The rate is a parameter, meant for 125 Hz to 1000 Hz, with 500 Hz as the default.

On each tick, an idle controller picks the next enabled channel and writes a control word. The control word carries that channel, the requested input range and a fixed acquisition mode. The controller then releases the write strobe, which starts the conversion. It polls the synchronized, active-low completion line, and reads the result as a low byte and then a high nibble.

Each assembled 12-bit result leaves the block with its channel index and a one-cycle valid strobe. Two conditions are reported separately from the sample output:

- A tick that lands while a conversion is still running is counted as an overrun.
- A conversion whose completion line never answers is abandoned, and an error flag is raised.

Top module: `adc_scan_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it is released: `adc_cs_n`, `adc_wr_n` and `adc_rd_n` are high, `smp_valid` is low, `timeout_err` is low and `ovr_cnt` is zero.
- R2: A sample tick occurs every CLK_HZ/RATE_HZ clocks. A conversion starts only on a tick that finds the controller idle and `chan_en` non-zero. With short conversions, consecutive starts (falling edges of `adc_wr_n`) are exactly CLK_HZ/RATE_HZ clocks apart.
- R3: The control word on `adc_dout` has the following layout while `adc_wr_n` is low. Bits [2:0] hold the channel, bits [4:3] hold `range_sel`, bit 5 is 0 and bits [7:6] are 2'b01. `adc_wr_n` stays low for exactly STROBE_CLKS clocks.
- R4: `adc_int_n` is active-low and passes through two flip-flops. `adc_rd_n` falls exactly 3 clocks after `adc_int_n` falls.
- R5: The read has two halves, and `adc_rd_n` stays low for 2*STROBE_CLKS clocks in total.
  - The first STROBE_CLKS clocks read the low byte with `adc_hben` low.
  - The next STROBE_CLKS clocks read the high nibble with `adc_hben` high.
  - Each half latches `adc_din` on its final cycle only.
  - `smp_data` = {high-read bits [3:0], low-read byte}, and bits [7:4] of the high read are discarded.
- R6: `smp_valid` is a one-cycle pulse. `smp_data` and `smp_chan` are valid while it is high.
- R7: Channels are served round-robin in ascending order over `chan_en`, wrapping from 7 to 0. The search starts just after the last completed channel, or at channel 0 after reset. With `chan_en` zero, no bus cycle starts and no overrun is counted.
- R8: Each tick that arrives while a conversion is in progress increments `ovr_cnt` by one, saturating. The running conversion is unaffected.
- R9: If done is not seen within DONE_TIMEOUT polling clocks, the controller returns to idle and sets `timeout_err`. The next start retries the same channel. A completed sample clears `timeout_err`.
- R10: `adc_cs_n` is low whenever `adc_wr_n` or `adc_rd_n` is low, and `adc_wr_n` and `adc_rd_n` are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | N_CH | Channel enable mask |
| range_sel | input | 2 | Input range code placed in the control word |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_wr_n | output | 1 | Control word write strobe, active low |
| adc_rd_n | output | 1 | Result read strobe, active low |
| adc_hben | output | 1 | High byte select during reads |
| adc_dout | output | 8 | Control word toward the converter |
| adc_doe | output | 1 | Output enable for `adc_dout` on a shared bus |
| adc_din | input | 8 | Data read from the converter |
| adc_int_n | input | 1 | Conversion complete, active low, asynchronous |
| smp_data | output | 12 | Assembled sample |
| smp_chan | output | CH_W | Channel index of the sample |
| smp_valid | output | 1 | One-cycle sample strobe |
| ovr_cnt | output | OVR_W | Saturating count of overrun ticks |
| timeout_err | output | 1 | Completion timeout flag |

## Verification
The bench builds the block with CLK_HZ=64000, RATE_HZ=1000, STROBE_CLKS=3 and DONE_TIMEOUT=100. With these values a tick comes every 64 clocks, so a full scan over a sparse mask takes a few hundred cycles. A converter model with a 70-clock conversion delay makes a tick land inside the polling state, which produces a single overrun. Muting the model triggers the 100-clock timeout and then the retry of the same channel within one further tick. The model holds junk data on the bus for the first cycles of each read half, which checks that the block latches only on the last cycle of each strobe.

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl #(
  parameter int CLK_HZ       = 1_000_000,
  parameter int RATE_HZ      = 500,
  parameter int N_CH         = 8,
  parameter int STROBE_CLKS  = 3,
  parameter int DONE_TIMEOUT = 4096,
  parameter int OVR_W        = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [N_CH-1:0]              chan_en,
  input  logic [1:0]                   range_sel,
  output logic                         adc_cs_n,
  output logic                         adc_wr_n,
  output logic                         adc_rd_n,
  output logic                         adc_hben,
  output logic [7:0]                   adc_dout,
  output logic                         adc_doe,
  input  logic [7:0]                   adc_din,
  input  logic                         adc_int_n,
  output logic [11:0]                  smp_data,
  output logic [$clog2(N_CH)-1:0]      smp_chan,
  output logic                         smp_valid,
  output logic [OVR_W-1:0]             ovr_cnt,
  output logic                         timeout_err
);
  localparam int CH_W  = $clog2(N_CH);
  localparam int DIV   = CLK_HZ / RATE_HZ;
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(DONE_TIMEOUT + 1);
  localparam logic [1:0] ACQ_MODE = 2'b01;

  typedef enum logic [2:0] {S_IDLE, S_WR, S_GO, S_POLL, S_RLO, S_RHI} st_t;

  st_t              st;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       int_sync;
  logic [CH_W-1:0]  cur, nxt;
  logic [7:0]       lo_q;

  function automatic logic [CH_W-1:0] first_en(input logic [N_CH-1:0] m,
                                               input logic [CH_W-1:0] s);
    first_en = s;
    for (int i = N_CH - 1; i >= 0; i--) begin
      int k;
      k = (int'(s) + i) % N_CH;
      if (m[k]) first_en = CH_W'(k);
    end
  endfunction

  wire tick       = (div_q == DIV_W'(DIV - 1));
  wire done_s     = ~int_sync[1];
  wire strobe_end = (cnt == CNT_W'(STROBE_CLKS - 1));
  wire poll_end   = (cnt == CNT_W'(DONE_TIMEOUT - 1));

  assign adc_wr_n = (st != S_WR);
  assign adc_rd_n = !(st == S_RLO || st == S_RHI);
  assign adc_cs_n = adc_wr_n & adc_rd_n;
  assign adc_hben = (st == S_RHI);
  assign adc_doe  = (st == S_WR);
  assign adc_dout = {ACQ_MODE, 1'b0, range_sel, 3'(cur)};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q    <= '0;
      int_sync <= 2'b11;
    end else begin
      div_q    <= tick ? '0 : div_q + 1'b1;
      int_sync <= {int_sync[0], adc_int_n};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      cur         <= '0;
      nxt         <= '0;
      lo_q        <= '0;
      smp_data    <= '0;
      smp_chan    <= '0;
      smp_valid   <= 1'b0;
      ovr_cnt     <= '0;
      timeout_err <= 1'b0;
    end else begin
      smp_valid <= 1'b0;
      if (tick && st != S_IDLE && ovr_cnt != '1) ovr_cnt <= ovr_cnt + 1'b1;
      case (st)
        S_IDLE: if (tick && |chan_en) begin
          cur <= first_en(chan_en, nxt);
          cnt <= '0;
          st  <= S_WR;
        end
        S_WR, S_GO: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) st <= (st == S_WR) ? S_GO : S_POLL;
        end
        S_POLL: begin
          cnt <= cnt + 1'b1;
          if (done_s) begin
            cnt <= '0;
            st  <= S_RLO;
          end else if (poll_end) begin
            cnt         <= '0;
            timeout_err <= 1'b1;
            st          <= S_IDLE;
          end
        end
        S_RLO: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) begin
            lo_q <= adc_din;
            st   <= S_RHI;
          end
        end
        S_RHI: begin
          cnt <= strobe_end ? '0 : cnt + 1'b1;
          if (strobe_end) begin
            smp_data    <= {adc_din[3:0], lo_q};
            smp_chan    <= cur;
            smp_valid   <= 1'b1;
            timeout_err <= 1'b0;
            nxt         <= (int'(cur) == N_CH - 1) ? '0 : cur + 1'b1;
            st          <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module adc_scan_ctrl_chk #(
  parameter int STROBE_CLKS = 3,
  parameter int OVR_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             wr_n,
  input logic             rd_n,
  input logic             hben,
  input logic             smp_valid,
  input logic             timeout_err,
  input logic [OVR_W-1:0] ovr_cnt
);
  logic [15:0] wr_run, hb_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_run <= '0;
      hb_run <= '0;
    end else begin
      wr_run <= wr_n ? '0 : wr_run + 1'b1;
      hb_run <= hben ? hb_run + 1'b1 : '0;
    end
  end

  p_wr_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> wr_run == 16'(STROBE_CLKS));
  p_hb_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hben) |-> hb_run == 16'(STROBE_CLKS));
  p_hb_in_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hben |-> !rd_n);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |=> !smp_valid);
  p_ovr_mono_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ovr_cnt >= $past(ovr_cnt));
  p_err_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> (cs_n && wr_n && rd_n));
  p_valid_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !timeout_err);
  p_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n || !rd_n) |-> !cs_n);
  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!wr_n && !rd_n));
endmodule

bind adc_scan_ctrl adc_scan_ctrl_chk #(.STROBE_CLKS(STROBE_CLKS), .OVR_W(OVR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(adc_cs_n), .wr_n(adc_wr_n), .rd_n(adc_rd_n),
  .hben(adc_hben), .smp_valid(smp_valid), .timeout_err(timeout_err), .ovr_cnt(ovr_cnt)
);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int TICK = 64;

  logic clk = 0, rst_n = 0;
  logic [7:0] chan_en = '0;
  logic [1:0] range_sel = 2'b10;
  logic adc_cs_n, adc_wr_n, adc_rd_n, adc_hben, adc_doe, smp_valid, timeout_err;
  logic [7:0] adc_dout, adc_din, ovr_cnt;
  logic [11:0] smp_data;
  logic [2:0] smp_chan;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_scan_ctrl #(.CLK_HZ(64000), .RATE_HZ(1000), .N_CH(8), .STROBE_CLKS(3),
                  .DONE_TIMEOUT(100), .OVR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .range_sel(range_sel),
    .adc_cs_n(adc_cs_n), .adc_wr_n(adc_wr_n), .adc_rd_n(adc_rd_n), .adc_hben(adc_hben),
    .adc_dout(adc_dout), .adc_doe(adc_doe), .adc_din(adc_din), .adc_int_n(adc_int_n),
    .smp_data(smp_data), .smp_chan(smp_chan), .smp_valid(smp_valid),
    .ovr_cnt(ovr_cnt), .timeout_err(timeout_err));

  // converter model
  logic adc_int_n = 1, prev_wr = 1, prev_hb = 0, mute = 0;
  logic [7:0] cap_ctrl = '0;
  logic [11:0] res_q = '0;
  int dly = 0, dly_set = 8, seq = 0, rdcnt = 0;

  always @(posedge clk) begin
    prev_wr <= adc_wr_n;
    prev_hb <= adc_hben;
    if (!adc_wr_n) cap_ctrl <= adc_dout;
    if (!prev_wr && adc_wr_n) begin
      adc_int_n <= 1;
      res_q <= 12'(int'(cap_ctrl[2:0]) * 397 + seq * 13 + 90);
      seq <= seq + 1;
      dly <= mute ? 0 : dly_set;
    end else if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) adc_int_n <= 0;
    end
    if (!adc_rd_n) adc_int_n <= 1;
    rdcnt <= (adc_rd_n || adc_hben != prev_hb) ? 0 : rdcnt + 1;
  end
  assign adc_din = (!adc_rd_n && rdcnt >= 1 && adc_hben == prev_hb) ?
                   (adc_hben ? {4'hC, res_q[11:8]} : res_q[7:0]) : 8'h5A;

  // bus monitor
  int cyc = 0, t_start_last = 0, t_start_prev = 0, t_int_fall = 0, t_rd_fall = 0;
  int wr_lo = 0, rd_lo = 0, hb_hi = 0, wr_w = 0, rd_w = 0, hb_w = 0, n_starts = 0, bad_bus = 0;
  logic m_wr = 1, m_rd = 1, m_int = 1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (m_wr && !adc_wr_n) begin n_starts++; t_start_prev = t_start_last; t_start_last = cyc; end
      if (m_int && !adc_int_n) t_int_fall = cyc;
      if (m_rd && !adc_rd_n) t_rd_fall = cyc;
      if (!adc_wr_n) wr_lo++; else if (wr_lo != 0) begin wr_w = wr_lo; wr_lo = 0; end
      if (!adc_rd_n) rd_lo++; else if (rd_lo != 0) begin rd_w = rd_lo; rd_lo = 0; end
      if (adc_hben) hb_hi++; else if (hb_hi != 0) begin hb_w = hb_hi; hb_hi = 0; end
      if (((!adc_wr_n || !adc_rd_n) && adc_cs_n) || (!adc_wr_n && !adc_rd_n)) bad_bus++;
    end
    m_wr = adc_wr_n; m_rd = adc_rd_n; m_int = adc_int_n;
  end

  int n_tests = 0, n_fail = 0;
  int ptr = 0;
  bit finished = 0;

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_ch(input logic [7:0] m, input int s);
    for (int i = 0; i < 8; i++) if (m[(s + i) % 8]) return (s + i) % 8;
    return s;
  endfunction

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 600; i++) begin
      step();
      if (smp_valid) begin got = 1; break; end
    end
  endtask

  task automatic check_sample(input string tag);
    int e;
    e = exp_ch(chan_en, ptr);
    chk(int'(smp_chan) == e, {tag, " R7 channel"}, smp_chan, e);
    chk(smp_data == res_q, {tag, " R5 data"}, smp_data, res_q);
    chk(cap_ctrl == {2'b01, 1'b0, range_sel, 3'(e)}, {tag, " R3 control word"}, cap_ctrl,
        {2'b01, 1'b0, range_sel, 3'(e)});
    ptr = (int'(smp_chan) + 1) % 8;
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (4) step();
    chk(adc_cs_n && adc_wr_n && adc_rd_n, "R1 strobes idle in reset", {adc_cs_n, adc_wr_n, adc_rd_n}, 7);
    rst_n = 1;
    step();
    chk(!smp_valid, "R1 valid low", smp_valid, 0);
    chk(!timeout_err, "R1 err low", timeout_err, 0);
    chk(ovr_cnt == 0, "R1 overrun zero", ovr_cnt, 0);
    chk(adc_cs_n, "R1 cs high", adc_cs_n, 1);
  endtask

  task automatic t_scan();
    bit got;
    chan_en = 8'b1010_0101;
    range_sel = 2'b10;
    for (int n = 0; n < 6; n++) begin
      wait_valid(got);
      chk(got, "R6 sample arrives", got, 1);
      check_sample("scan");
      if (n == 1) begin
        chk(t_start_last - t_start_prev == TICK, "R2 start spacing", t_start_last - t_start_prev, TICK);
        chk(wr_w == 3, "R3 write strobe width", wr_w, 3);
        chk(rd_w == 6, "R5 read strobe width", rd_w, 6);
        chk(hb_w == 3, "R5 high byte select width", hb_w, 3);
        chk(t_rd_fall - t_int_fall == 3, "R4 done sync latency", t_rd_fall - t_int_fall, 3);
      end
      step();
      if (n == 0) chk(!smp_valid, "R6 valid one cycle", smp_valid, 0);
    end
    range_sel = 2'b01;
    chan_en = 8'b0100_0000;
    wait_valid(got);
    check_sample("single");
  endtask

  task automatic t_mask_zero();
    bit got;
    int s0, o0;
    wait_valid(got);
    check_sample("pre-zero");
    chan_en = 8'h00;
    s0 = n_starts; o0 = ovr_cnt;
    repeat (300) step();
    chk(n_starts == s0, "R7 zero mask no bus cycle", n_starts - s0, 0);
    chk(int'(ovr_cnt) == o0, "R7 zero mask no overrun", ovr_cnt, o0);
    chan_en = 8'b0001_1000;
    wait_valid(got);
    check_sample("after-zero");
  endtask

  task automatic t_overrun();
    bit got;
    int o0;
    dly_set = 70;
    o0 = ovr_cnt;
    wait_valid(got);
    chk(got, "R8 slow sample arrives", got, 1);
    check_sample("overrun");
    chk(int'(ovr_cnt) == o0 + 1, "R8 overrun count", ovr_cnt, o0 + 1);
    dly_set = 8;
    o0 = ovr_cnt;
    wait_valid(got);
    check_sample("post-overrun");
    chk(int'(ovr_cnt) == o0, "R8 no overrun when fast", ovr_cnt, o0);
  endtask

  task automatic t_timeout();
    bit got, seen_valid;
    int e;
    chan_en = 8'b1000_0010;
    e = exp_ch(chan_en, ptr);
    mute = 1;
    seen_valid = 0;
    for (int i = 0; i < 400 && !timeout_err; i++) begin
      step();
      if (smp_valid) seen_valid = 1;
    end
    chk(timeout_err, "R9 timeout flag", timeout_err, 1);
    chk(!seen_valid, "R9 no sample on timeout", seen_valid, 0);
    chk(adc_cs_n, "R9 back to idle", adc_cs_n, 1);
    mute = 0;
    wait_valid(got);
    chk(int'(smp_chan) == e, "R9 same channel retried", smp_chan, e);
    chk(!timeout_err, "R9 err cleared by sample", timeout_err, 0);
    check_sample("retry");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_scan();
    t_mask_zero();
    t_overrun();
    t_timeout();
    chk(bad_bus == 0, "R10 strobe exclusion and chip select", bad_bus, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule